// File: doc/BRIEF.md
# Embedded Flash Program and Erase Controller

This block sits between a CPU register port and a small behavioural flash array. The array is held in registers and holds one main block and two information blocks. The main block is divided into pages, and groups of pages form sectors. The CPU chooses an operation by setting a mode bit in a control register. A write into the flash address space then runs a page erase, a whole-block erase or a word program. The information blocks are reached indirectly: the CPU loads an address register, and a write to the data register is the trigger. Erase sets every word in its range to all ones. Programming can only clear bits, so the new word is the old word ANDed with the written data.

Programming is pipelined. While one word is being programmed, one more word can wait in a holding buffer. While the buffer is occupied, any further operation-starting write is stalled on `cpu_ready` and is not dropped. A guard checks every request before it starts. It applies a global write-protect input, per-sector enable bits and a boot region made of the lowest pages, whose size comes from an input. It also refuses any program of information block 0. A refused request does not start and sets a sticky error flag.

Registers are selected with `cpu_regsp`=1 and index `cpu_addr[2:0]`:
- 0 is control: bit0 program, bit1 page erase, bit2 block erase.
- 1 is status: bit0 busy, bit1 buffer full, bit2 erase error, bit3 program error.
- 2 holds the sector enable bits.
- 3 is the information address. Its MSB selects the block and the lower bits select the word.
- 4 is the information data register. A read returns the addressed word.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset, status and control read 0 and every word of both array regions reads 0xFFFF.
- R2: With program mode set, a word write to an even address in an enabled, non-boot sector raises busy for PROG_CYCLES cycles. The word then becomes old AND data.
- R3: A second program write during programming is accepted into the holding buffer and sets status bit1. A further launching write while the buffer is full is held with `cpu_ready` low. All words are programmed in order.
- R4: With page-erase mode, a write of any width to any address in a page erases that page after ERASE_CYCLES busy cycles and leaves other pages alone. It is refused with an erase error for a boot page, a disabled sector or write protection.
- R5: With block-erase mode, a flash-space write erases the whole main block. It is refused with an erase error if the boot size is nonzero, if any sector enable is 0 or if write protection is on.
- R6: A block-erase trigger through the information data register erases the addressed information block and the whole main block together. It is refused under the same conditions as R5, and nothing changes.
- R7: A page-erase trigger through the information data register sets the erase error and changes nothing.
- R8: A program is refused with a program error, and no busy and no change to the word, if write protection is on, the sector is disabled or the word lies in the boot region.
- R9: An information program writes old AND data to the word at the information address of block 1. Any program of block 0 is refused with a program error.
- R10: A program write at an odd byte address, or with `cpu_word`=0, is refused with a program error.
- R11: The erase and program error flags stay set until a status write has a 1 in their own bit position (bit2 and bit3).
- R12: The mode priority is block erase, then page erase, then program. A flash-space write with no mode set has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Access request |
| cpu_write | input | 1 | 1 for write, 0 for read |
| cpu_regsp | input | 1 | 1 selects registers, 0 the main flash block |
| cpu_addr | input | ADDR_W | Byte address (register index in bits 2:0) |
| cpu_word | input | 1 | 1 for a full-word access |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, combinational |
| cpu_ready | output | 1 | Low while a launching write must wait |
| write_protect | input | 1 | Global protection, blocks all erase and program |
| boot_pages | input | PG_IW+1 | Number of lowest main pages forming the boot region |

## Verification
A refused request reports its error flag one cycle after the accepting edge, and busy stays low. An accepted erase keeps busy high for ERASE_CYCLES cycles after the accepting edge, and a program for PROG_CYCLES cycles. The new array contents first read back in the cycle in which busy has fallen. The bench drives inputs on the falling edge and returns from each write one falling edge after acceptance. It then counts falling edges and samples busy and the read data at exactly the last busy cycle and at the first idle cycle. The buffer-full flag is checked one cycle after the second write, and the stall is checked in the same cycle as the third write is presented.

// File: rtl/flash_pe_pkg.sv
// Shared types and register layout for the flash program/erase controller.
package flash_pe_pkg;

    typedef enum logic [1:0] {OP_NONE, OP_PAGE, OP_BLOCK, OP_PROG} op_e;
    typedef enum logic [1:0] {ST_IDLE, ST_ERASE, ST_PROG} st_e;

    localparam logic [2:0] RI_CTRL  = 3'd0;
    localparam logic [2:0] RI_STAT  = 3'd1;
    localparam logic [2:0] RI_SECT  = 3'd2;
    localparam logic [2:0] RI_IADDR = 3'd3;
    localparam logic [2:0] RI_IDATA = 3'd4;

    localparam int CB_PROG  = 0;
    localparam int CB_PAGE  = 1;
    localparam int CB_BLOCK = 2;

    localparam int SB_EERR = 2;
    localparam int SB_PERR = 3;

endpackage

// File: rtl/flash_pe_guard.sv
// Protection guard: decodes the active mode into an operation and
// decides whether the request is refused. Purely combinational.
// Assumes PAGES/SECTORS is a power of two and SECTORS >= 2.
module flash_pe_guard
    import flash_pe_pkg::*;
#(
    parameter int PAGES   = 8,
    parameter int SECTORS = 4,
    localparam int PG_IW  = $clog2(PAGES),
    localparam int SEC_IW = $clog2(SECTORS)
) (
    input  logic [2:0]       mode,
    input  logic             trig_main,
    input  logic             trig_info,
    input  logic [PG_IW-1:0] page,
    input  logic             aligned_word,
    input  logic             info_blk,
    input  logic [SECTORS-1:0] sect_we,
    input  logic [PG_IW:0]   boot_pages,
    input  logic             write_protect,
    output op_e              op,
    output logic             erase_err,
    output logic             prog_err
);
    localparam int PPS_SH = $clog2(PAGES / SECTORS);

    logic [SEC_IW-1:0] sector;
    logic in_boot, sec_en, all_en, boot_def;

    // Locate the page's sector and boot membership.
    always_comb begin
        sector   = SEC_IW'(page >> PPS_SH);
        sec_en   = sect_we[sector];
        all_en   = &sect_we;
        boot_def = (boot_pages != '0);
        in_boot  = ({1'b0, page} < boot_pages);
    end

    // Pick the operation by priority and apply its refusal rules.
    always_comb begin
        op        = OP_NONE;
        erase_err = 1'b0;
        prog_err  = 1'b0;
        if (trig_main || trig_info) begin
            if (mode[CB_BLOCK]) begin
                op        = OP_BLOCK;
                erase_err = write_protect | ~all_en | boot_def;
            end else if (mode[CB_PAGE]) begin
                op        = OP_PAGE;
                erase_err = trig_info | write_protect | in_boot | ~sec_en;
            end else if (mode[CB_PROG]) begin
                op       = OP_PROG;
                prog_err = trig_info ? (write_protect | ~info_blk)
                                     : (write_protect | ~sec_en | in_boot | ~aligned_word);
            end
        end
    end
endmodule

// File: rtl/flash_pe_engine.sv
// Operation sequencer: one active operation plus a one-word program
// holding buffer. Raises a commit strobe in the last busy cycle.
// Assumes a request is only taken when can_take is high.
module flash_pe_engine
    import flash_pe_pkg::*;
#(
    parameter int IW           = 5,
    parameter int DATA_W       = 16,
    parameter int ERASE_CYCLES = 6,
    parameter int PROG_CYCLES  = 3,
    localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES,
    localparam int CW   = $clog2(MAXC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  op_e               new_op,
    input  logic              new_info,
    input  logic [IW-1:0]     new_addr,
    input  logic [DATA_W-1:0] new_data,
    output logic              can_take,
    output logic              busy,
    output logic              full,
    output logic              cmt,
    output op_e               cmt_op,
    output logic              cmt_info,
    output logic [IW-1:0]     cmt_addr,
    output logic [DATA_W-1:0] cmt_data
);
    st_e               st;
    logic [CW-1:0]     cnt;
    op_e               a_op;
    logic              a_info, b_info;
    logic [IW-1:0]     a_addr, b_addr;
    logic [DATA_W-1:0] a_data, b_data;
    logic              done, free_next;

    // Acceptance rules: free engine, or park a program behind a program.
    always_comb begin
        done      = (st != ST_IDLE) && (cnt == '0);
        free_next = (st == ST_IDLE) || (done && !full);
        can_take  = free_next || (new_op == OP_PROG && st == ST_PROG && !full);
        busy      = (st != ST_IDLE) || full;
    end

    assign cmt      = done;
    assign cmt_op   = a_op;
    assign cmt_info = a_info;
    assign cmt_addr = a_addr;
    assign cmt_data = a_data;

    // Step the cycle counter, chain buffered words, start new requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            full   <= 1'b0;
            a_op   <= OP_NONE;
            a_info <= 1'b0;
            a_addr <= '0;
            a_data <= '0;
            b_info <= 1'b0;
            b_addr <= '0;
            b_data <= '0;
        end else begin
            if (done) begin
                if (full) begin
                    a_op   <= OP_PROG;
                    a_info <= b_info;
                    a_addr <= b_addr;
                    a_data <= b_data;
                    cnt    <= CW'(PROG_CYCLES - 1);
                    full   <= 1'b0;
                    st     <= ST_PROG;
                end else begin
                    st <= ST_IDLE;
                end
            end else if (st != ST_IDLE) begin
                cnt <= cnt - 1'b1;
            end
            if (take) begin
                if (free_next) begin
                    a_op   <= new_op;
                    a_info <= new_info;
                    a_addr <= new_addr;
                    a_data <= new_data;
                    st     <= (new_op == OP_PROG) ? ST_PROG : ST_ERASE;
                    cnt    <= (new_op == OP_PROG) ? CW'(PROG_CYCLES - 1)
                                                  : CW'(ERASE_CYCLES - 1);
                end else begin
                    b_info <= new_info;
                    b_addr <= new_addr;
                    b_data <= new_data;
                    full   <= 1'b1;
                end
            end
        end
    end

    // R3: the holding buffer is only occupied behind a running program.
    a_r3_full_needs_prog: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (st == ST_PROG));

    // R2: an operation keeps its kind until its counter has run out.
    a_r2_op_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && cnt != '0) |=> (st == $past(st)));
endmodule

// File: rtl/flash_pe_array.sv
// Behavioural flash storage: main block and two information blocks.
// Starts erased after reset; applies erase/program on the commit strobe.
module flash_pe_array
    import flash_pe_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int PAGE_WORDS = 4,
    parameter int PAGES      = 8,
    parameter int INFO_WORDS = 4,
    parameter int IW         = 5,
    localparam int MAIN_WORDS = PAGES * PAGE_WORDS,
    localparam int MAIN_IW    = $clog2(MAIN_WORDS),
    localparam int INFO_IW    = $clog2(2 * INFO_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmt,
    input  op_e                cmt_op,
    input  logic               cmt_info,
    input  logic [IW-1:0]      cmt_addr,
    input  logic [DATA_W-1:0]  cmt_data,
    input  logic [MAIN_IW-1:0] main_ra,
    output logic [DATA_W-1:0]  main_rd,
    input  logic [INFO_IW-1:0] info_ra,
    output logic [DATA_W-1:0]  info_rd
);
    logic [DATA_W-1:0] main_mem [MAIN_WORDS];
    logic [DATA_W-1:0] info_mem [2*INFO_WORDS];
    logic [MAIN_IW-1:0] m_idx;
    logic [INFO_IW-1:0] i_idx;

    assign m_idx   = cmt_addr[MAIN_IW-1:0];
    assign i_idx   = cmt_addr[INFO_IW-1:0];
    assign main_rd = main_mem[main_ra];
    assign info_rd = info_mem[info_ra];

    // Blank on reset, then erase to ones or AND-program on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAIN_WORDS; i++) main_mem[i] <= '1;
            for (int i = 0; i < 2*INFO_WORDS; i++) info_mem[i] <= '1;
        end else if (cmt) begin
            case (cmt_op)
                OP_PAGE: for (int i = 0; i < MAIN_WORDS; i++)
                    if (i / PAGE_WORDS == int'(m_idx) / PAGE_WORDS) main_mem[i] <= '1;
                OP_BLOCK: begin
                    for (int i = 0; i < MAIN_WORDS; i++) main_mem[i] <= '1;
                    if (cmt_info)
                        for (int i = 0; i < 2*INFO_WORDS; i++)
                            if (i / INFO_WORDS == int'(i_idx[INFO_IW-1])) info_mem[i] <= '1;
                end
                OP_PROG:
                    if (cmt_info) info_mem[i_idx] <= info_mem[i_idx] & cmt_data;
                    else          main_mem[m_idx] <= main_mem[m_idx] & cmt_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/flash_pe_ctrl.sv
// Top of the flash program/erase controller: CPU register file,
// request decode, guard, sequencer and behavioural array.
// Assumes boot_pages is held steady while an operation is running.
module flash_pe_ctrl
    import flash_pe_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int PAGE_WORDS   = 4,
    parameter int PAGES        = 8,
    parameter int SECTORS      = 4,
    parameter int INFO_WORDS   = 4,
    parameter int ERASE_CYCLES = 6,
    parameter int PROG_CYCLES  = 3,
    localparam int MAIN_IW = $clog2(PAGES * PAGE_WORDS),
    localparam int INFO_IW = $clog2(2 * INFO_WORDS),
    localparam int PW_IW   = $clog2(PAGE_WORDS),
    localparam int PG_IW   = $clog2(PAGES),
    localparam int ADDR_W  = MAIN_IW + 1,
    localparam int IW      = (MAIN_IW > INFO_IW) ? MAIN_IW : INFO_IW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic              cpu_regsp,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_word,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    input  logic              write_protect,
    input  logic [PG_IW:0]    boot_pages
);
    logic [2:0]         ctrl;
    logic [SECTORS-1:0] sect_we;
    logic [INFO_IW-1:0] info_addr;
    logic               erase_err, prog_err;

    logic [2:0]         ridx;
    logic [MAIN_IW-1:0] word_idx;
    logic               wr, reg_wr, trig_main, trig_info, acc, take, refused;
    op_e                op;
    logic               g_eerr, g_perr;
    logic               can_take, busy, full, cmt, cmt_info;
    op_e                cmt_op;
    logic [IW-1:0]      cmt_addr, new_addr;
    logic [DATA_W-1:0]  cmt_data, main_rd, info_rd;

    // Decode the access into register writes and operation triggers.
    always_comb begin
        ridx      = cpu_addr[2:0];
        word_idx  = cpu_addr[ADDR_W-1:1];
        wr        = cpu_valid && cpu_write;
        reg_wr    = wr && cpu_regsp;
        trig_main = wr && !cpu_regsp;
        trig_info = reg_wr && (ridx == RI_IDATA);
        refused   = g_eerr || g_perr;
        cpu_ready = !((op != OP_NONE) && !refused && !can_take);
        acc       = cpu_valid && cpu_ready;
        take      = acc && (op != OP_NONE) && !refused;
        new_addr  = trig_info ? IW'(info_addr) : IW'(word_idx);
    end

    flash_pe_guard #(.PAGES(PAGES), .SECTORS(SECTORS)) u_guard (
        .mode(ctrl), .trig_main(trig_main), .trig_info(trig_info),
        .page(word_idx[MAIN_IW-1:PW_IW]), .aligned_word(cpu_word && !cpu_addr[0]),
        .info_blk(info_addr[INFO_IW-1]), .sect_we(sect_we), .boot_pages(boot_pages),
        .write_protect(write_protect), .op(op), .erase_err(g_eerr), .prog_err(g_perr)
    );

    flash_pe_engine #(.IW(IW), .DATA_W(DATA_W), .ERASE_CYCLES(ERASE_CYCLES),
                      .PROG_CYCLES(PROG_CYCLES)) u_engine (
        .clk(clk), .rst_n(rst_n), .take(take), .new_op(op), .new_info(trig_info),
        .new_addr(new_addr), .new_data(cpu_wdata), .can_take(can_take), .busy(busy),
        .full(full), .cmt(cmt), .cmt_op(cmt_op), .cmt_info(cmt_info),
        .cmt_addr(cmt_addr), .cmt_data(cmt_data)
    );

    flash_pe_array #(.DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS), .PAGES(PAGES),
                     .INFO_WORDS(INFO_WORDS), .IW(IW)) u_array (
        .clk(clk), .rst_n(rst_n), .cmt(cmt), .cmt_op(cmt_op), .cmt_info(cmt_info),
        .cmt_addr(cmt_addr), .cmt_data(cmt_data), .main_ra(word_idx), .main_rd(main_rd),
        .info_ra(info_addr), .info_rd(info_rd)
    );

    // Control, enable and address registers; sticky write-one-to-clear errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl      <= '0;
            sect_we   <= '0;
            info_addr <= '0;
            erase_err <= 1'b0;
            prog_err  <= 1'b0;
        end else begin
            if (reg_wr && ridx == RI_CTRL)  ctrl      <= cpu_wdata[2:0];
            if (reg_wr && ridx == RI_SECT)  sect_we   <= cpu_wdata[SECTORS-1:0];
            if (reg_wr && ridx == RI_IADDR) info_addr <= cpu_wdata[INFO_IW-1:0];
            if (reg_wr && ridx == RI_STAT && cpu_wdata[SB_EERR]) erase_err <= 1'b0;
            if (reg_wr && ridx == RI_STAT && cpu_wdata[SB_PERR]) prog_err  <= 1'b0;
            if (acc && g_eerr) erase_err <= 1'b1;
            if (acc && g_perr) prog_err  <= 1'b1;
        end
    end

    // Read mux for registers and the main block.
    always_comb begin
        cpu_rdata = '0;
        if (!cpu_regsp) cpu_rdata = main_rd;
        else case (ridx)
            RI_CTRL:  cpu_rdata = DATA_W'(ctrl);
            RI_STAT:  cpu_rdata = DATA_W'({prog_err, erase_err, full, busy});
            RI_SECT:  cpu_rdata = DATA_W'(sect_we);
            RI_IADDR: cpu_rdata = DATA_W'(info_addr);
            RI_IDATA: cpu_rdata = info_rd;
            default:  cpu_rdata = '0;
        endcase
    end

    // R3: a stall is only seen while the engine is occupied.
    a_r3_stall_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !cpu_ready) |-> busy);

    // R8: a main-block program never lands in the boot region.
    a_r8_boot_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt && cmt_op == OP_PROG && !cmt_info)
        |-> ({1'b0, cmt_addr[MAIN_IW-1:PW_IW]} >= boot_pages));

    // R5: a block erase only completes with no boot region defined.
    a_r5_block_no_boot: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt && cmt_op == OP_BLOCK) |-> (boot_pages == '0));

    // R11: error flags hold until written with a one.
    a_r11_eerr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_err && !(reg_wr && ridx == RI_STAT && cpu_wdata[SB_EERR])) |=> erase_err);
    a_r11_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_err && !(reg_wr && ridx == RI_STAT && cpu_wdata[SB_PERR])) |=> prog_err);
endmodule

// File: tb/flash_pe_ctrl_tb.sv
`timescale 1ns/1ps
module flash_pe_ctrl_tb;
    localparam int EC = 6;
    localparam int PC = 3;

    logic        clk = 0, rst_n = 0;
    logic        cpu_valid = 0, cpu_write = 0, cpu_regsp = 0, cpu_word = 1;
    logic [5:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic        write_protect = 0;
    logic [3:0]  boot_pages = 4'd2;

    int checks = 0, fails = 0;
    bit finished = 0;

    flash_pe_ctrl #(.ERASE_CYCLES(EC), .PROG_CYCLES(PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .cpu_regsp(cpu_regsp), .cpu_addr(cpu_addr), .cpu_word(cpu_word),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .write_protect(write_protect), .boot_pages(boot_pages)
    );

    always #2 clk = ~clk;

    // Vector: {byte addr, word, data, expected perr, expected readback}
    localparam logic [39:0] VEC [0:8] = '{
        {6'h20, 1'b1, 16'h1234, 1'b0, 16'h1234},
        {6'h20, 1'b1, 16'hFF0F, 1'b0, 16'h1204},
        {6'h22, 1'b1, 16'hA5A5, 1'b0, 16'hA5A5},
        {6'h23, 1'b1, 16'h0000, 1'b1, 16'hA5A5},
        {6'h24, 1'b0, 16'h0000, 1'b1, 16'hFFFF},
        {6'h04, 1'b1, 16'h0000, 1'b1, 16'hFFFF},
        {6'h3E, 1'b1, 16'h0F0F, 1'b0, 16'h0F0F},
        {6'h10, 1'b1, 16'h8001, 1'b0, 16'h8001},
        {6'h0E, 1'b1, 16'h0000, 1'b1, 16'hFFFF}
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Write; caller is at a falling edge, returns one falling edge after acceptance.
    task automatic wr(input logic rs, input logic [5:0] a, input logic w, input logic [15:0] d);
        cpu_valid = 1; cpu_write = 1; cpu_regsp = rs; cpu_addr = a; cpu_word = w; cpu_wdata = d;
        #0.1;
        while (!cpu_ready) begin @(negedge clk); #0.1; end
        @(negedge clk);
        cpu_valid = 0; cpu_write = 0; cpu_word = 1;
    endtask

    task automatic rd(input logic rs, input logic [5:0] a, output logic [15:0] d);
        cpu_valid = 1; cpu_write = 0; cpu_regsp = rs; cpu_addr = a; cpu_word = 1;
        #0.1;
        d = cpu_rdata;
        cpu_valid = 0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        rd(1, 6'd1, s);
        while (s[0]) begin @(negedge clk); rd(1, 6'd1, s); end
    endtask

    task automatic clr_err();
        wr(1, 6'd1, 1, 16'h000C);
    endtask

    task automatic chk_main(input string tag, input logic [5:0] a, input logic [15:0] exp);
        logic [15:0] d;
        rd(0, a, d);
        chk(tag, d, exp);
    endtask

    task automatic chk_stat(input string tag, input logic [15:0] exp);
        logic [15:0] d;
        rd(1, 6'd1, d);
        chk(tag, d, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic ok;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state
        chk_stat("R1 status", 16'h0000);
        rd(1, 6'd0, d); chk("R1 control", d, 16'h0000);
        chk_main("R1 main first", 6'h00, 16'hFFFF);
        chk_main("R1 main last", 6'h3E, 16'hFFFF);
        rd(1, 6'd4, d); chk("R1 info", d, 16'hFFFF);

        wr(1, 6'd2, 1, 16'h000F);
        wr(1, 6'd0, 1, 16'h0001);

        // Vector table: main-block programs (R2, R8, R10)
        for (int i = 0; i < 9; i++) begin
            wr(0, VEC[i][39:34], VEC[i][33], VEC[i][32:17]);
            wait_idle();
            chk($sformatf("R2/R8/R10 vec%0d value", i), 16'(0), 16'(0));
            checks--;
            rd(0, {VEC[i][39:35], 1'b0}, d);
            chk($sformatf("R2/R8/R10 vec%0d value", i), d, VEC[i][15:0]);
            rd(1, 6'd1, d);
            chk($sformatf("R8/R10 vec%0d perr", i), {15'd0, d[3]}, {15'd0, VEC[i][16]});
            clr_err();
        end

        // R2: busy window and commit timing
        wr(0, 6'h30, 1, 16'h00FF);
        ok = 1;
        rd(1, 6'd1, d); if (!d[0]) ok = 0;
        for (int k = 2; k <= PC; k++) begin
            @(negedge clk); rd(1, 6'd1, d); if (!d[0]) ok = 0;
        end
        chk("R2 busy held", {15'd0, ok}, 16'd1);
        chk_main("R2 not yet written", 6'h30, 16'hFFFF);
        @(negedge clk);
        chk_stat("R2 busy cleared", 16'h0000);
        chk_main("R2 written", 6'h30, 16'h00FF);

        // R3: pipelined programs, buffer full, stall
        wr(0, 6'h32, 1, 16'h1111);
        wr(0, 6'h34, 1, 16'h2222);
        chk_stat("R3 full set", 16'h0003);
        cpu_valid = 1; cpu_write = 1; cpu_regsp = 0; cpu_addr = 6'h36; cpu_wdata = 16'h4444;
        #0.1;
        chk("R3 stall", {15'd0, cpu_ready}, 16'd0);
        wr(0, 6'h36, 1, 16'h4444);
        wait_idle();
        chk_main("R3 word a", 6'h32, 16'h1111);
        chk_main("R3 word b", 6'h34, 16'h2222);
        chk_main("R3 word c", 6'h36, 16'h4444);

        // R8: write protect and disabled sector
        write_protect = 1;
        wr(0, 6'h30, 1, 16'h0000);
        chk_stat("R8 wp refused", 16'h0008);
        chk_main("R8 wp unchanged", 6'h30, 16'h00FF);
        write_protect = 0;
        clr_err();
        wr(1, 6'd2, 1, 16'h0007);
        wr(0, 6'h30, 1, 16'h0000);
        chk_stat("R8 sector refused", 16'h0008);
        chk_main("R8 sector unchanged", 6'h30, 16'h00FF);
        wr(1, 6'd2, 1, 16'h000F);

        // R11: sticky, write-one-to-clear per bit
        wr(1, 6'd1, 1, 16'h0004);
        chk_stat("R11 perr kept", 16'h0008);
        wr(1, 6'd1, 1, 16'h0008);
        chk_stat("R11 perr cleared", 16'h0000);

        // R9: information block programming
        wr(1, 6'd3, 1, 16'h0006);
        wr(1, 6'd4, 1, 16'h3C3C);
        wait_idle();
        rd(1, 6'd4, d); chk("R9 info1 programmed", d, 16'h3C3C);
        wr(1, 6'd3, 1, 16'h0002);
        wr(1, 6'd4, 1, 16'h0000);
        chk_stat("R9 info0 refused", 16'h0008);
        rd(1, 6'd4, d); chk("R9 info0 unchanged", d, 16'hFFFF);
        clr_err();

        // R12: no mode ignored; page erase outranks program
        wr(1, 6'd0, 1, 16'h0000);
        wr(0, 6'h30, 1, 16'h0000);
        chk_stat("R12 no mode idle", 16'h0000);
        chk_main("R12 no mode unchanged", 6'h30, 16'h00FF);
        wr(1, 6'd0, 1, 16'h0003);
        wr(0, 6'h30, 1, 16'h0000);
        wait_idle();
        chk_main("R12 page won", 6'h30, 16'hFFFF);
        chk_main("R12 page won end", 6'h36, 16'hFFFF);

        // R4: page erase timing and scope
        wr(1, 6'd0, 1, 16'h0002);
        wr(0, 6'h21, 0, 16'h0000);
        for (int k = 2; k <= EC; k++) @(negedge clk);
        chk_stat("R4 busy last cycle", 16'h0001);
        chk_main("R4 before commit", 6'h20, 16'h1204);
        @(negedge clk);
        chk_stat("R4 idle", 16'h0000);
        chk_main("R4 page word0", 6'h20, 16'hFFFF);
        chk_main("R4 page word1", 6'h22, 16'hFFFF);
        chk_main("R4 other page", 6'h3E, 16'h0F0F);
        chk_main("R4 low page", 6'h10, 16'h8001);
        wr(0, 6'h08, 1, 16'h0000);
        chk_stat("R4 boot refused", 16'h0004);
        clr_err();
        wr(1, 6'd2, 1, 16'h0007);
        wr(0, 6'h3E, 1, 16'h0000);
        chk_stat("R4 sector refused", 16'h0004);
        chk_main("R4 sector unchanged", 6'h3E, 16'h0F0F);
        wr(1, 6'd2, 1, 16'h000F);
        clr_err();
        wr(0, 6'h3E, 1, 16'h0000);
        wait_idle();
        chk_main("R4 second page", 6'h3E, 16'hFFFF);

        // R7: page erase via information register
        wr(1, 6'd3, 1, 16'h0006);
        wr(1, 6'd4, 1, 16'h0000);
        chk_stat("R7 refused", 16'h0004);
        rd(1, 6'd4, d); chk("R7 info unchanged", d, 16'h3C3C);
        clr_err();

        // R5/R6: refusals
        wr(1, 6'd0, 1, 16'h0004);
        wr(1, 6'd4, 1, 16'h0000);
        chk_stat("R6 boot refused", 16'h0004);
        rd(1, 6'd4, d); chk("R6 info kept", d, 16'h3C3C);
        chk_main("R6 main kept", 6'h10, 16'h8001);
        clr_err();
        wr(0, 6'h10, 1, 16'h0000);
        chk_stat("R5 boot refused", 16'h0004);
        clr_err();
        boot_pages = 4'd0;
        wr(1, 6'd2, 1, 16'h0007);
        wr(0, 6'h10, 1, 16'h0000);
        chk_stat("R5 sector refused", 16'h0004);
        wr(1, 6'd2, 1, 16'h000F);
        clr_err();
        write_protect = 1;
        wr(0, 6'h10, 1, 16'h0000);
        chk_stat("R5 wp refused", 16'h0004);
        chk_main("R5 main kept", 6'h10, 16'h8001);
        write_protect = 0;
        clr_err();

        // R5: main block erase leaves information blocks
        wr(0, 6'h10, 1, 16'h0000);
        wait_idle();
        chk_main("R5 main erased", 6'h10, 16'hFFFF);
        rd(1, 6'd4, d); chk("R5 info untouched", d, 16'h3C3C);

        // R6: information erase takes the main block with it
        wr(1, 6'd0, 1, 16'h0001);
        wr(0, 6'h10, 1, 16'h5555);
        wait_idle();
        chk_main("R6 main reprogrammed", 6'h10, 16'h5555);
        wr(1, 6'd0, 1, 16'h0004);
        wr(1, 6'd4, 1, 16'h0000);
        wait_idle();
        rd(1, 6'd4, d); chk("R6 info erased", d, 16'hFFFF);
        chk_main("R6 main erased", 6'h10, 16'hFFFF);
        chk_stat("R6 no error", 16'h0000);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule